// File: doc/BRIEF.md
# Clock-Compensating Elastic Buffer

This block carries a stream of already word-aligned 10-bit symbols from a recovered receive clock into the local receive clock. The two clocks come from independent references, so their frequencies may differ by a few hundred ppm. A plain dual-clock queue would slowly fill or drain. The buffer has twenty storage entries. It keeps its occupancy near the middle by changing the number of skip symbols in the stream, and it does so only where a skip symbol directly follows a control symbol. Both symbol values come in on input ports and are expected to stay static while the block runs.

If the writing clock is faster, a skip that follows a control symbol is not stored. If the reading clock is faster, such a skip is sent out twice. Each domain keeps its own view of the occupancy. That view is built from Gray-coded pointers that cross through two-flop synchronisers, and the thresholds allow for the synchroniser delay. A single-cycle strobe reports each deletion and each insertion. Sticky flags report an overflow or an underflow.

The block is used directly after a word aligner and before symbol decoding. The configured skip value should be a neutral-disparity code group, so that adding or removing it leaves the running disparity unchanged.

Top module: `elastic_buf`

## Requirements
- R1: While a domain's reset is high, and in the cycle after it, that domain's outputs are quiet: out_valid, ins_stb and udf_flag on the read side, and del_stb and ovf_flag on the write side, are all 0. A reset clears both sticky flags.
- R2: After reset, out_valid stays 0 until at least 10 symbols have been accepted on the write side. The first valid output symbol is the first symbol written after reset.
- R3: ovf_flag is set when a symbol must be stored while the write side sees all 20 entries in use. The flag stays set until write reset.
- R4: underflow handling:
  - udf_flag is set when the read side has started and finds no stored symbol for a read cycle.
  - In that cycle out_valid is 0.
  - The flag stays set until read reset.
- R5: When no flag is set, every symbol except a skip that directly follows a control symbol comes out unchanged and in write order.
- R6: When the write clock is faster, skips that directly follow a control symbol are dropped. Each drop raises del_stb for exactly one write cycle, and no overflow occurs.
- R7: When the read clock is faster, some skips that directly follow a control symbol are output in two consecutive valid cycles. ins_stb is high in the cycle of the repeated copy, and no run of pattern skips at the output is longer than two.
- R8: A skip that is not directly preceded by a control symbol is never dropped or repeated. A control symbol that is not followed by a skip triggers nothing.
- R9: With equal write and read frequencies, the occupancy stays inside the band and no skip is inserted or deleted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Recovered (write) clock |
| wrst | input | 1 | Write-domain synchronous reset, active high |
| in_sym | input | 10 | Aligned symbol, one per write cycle |
| del_stb | output | 1 | One write cycle per dropped skip |
| ovf_flag | output | 1 | Sticky overflow |
| rclk | input | 1 | Local (read) clock |
| rrst | input | 1 | Read-domain synchronous reset, active high |
| out_valid | output | 1 | out_sym carries a symbol this read cycle |
| out_sym | output | 10 | Symbol delivered in the read domain |
| ins_stb | output | 1 | High with the repeated skip copy |
| udf_flag | output | 1 | Sticky underflow |
| ctrl_sym | input | 10 | Control symbol that opens the compensation pattern |
| skip_sym | input | 10 | Skip symbol that may be dropped or repeated |

## Verification
The hardest situation to reach from the ports is a sustained drift of the occupancy toward one threshold. In that situation the compensation events must actually fire, while lone skips and unpaired control symbols in the same stream must stay untouched. The bench reaches it by running the two clocks two percent apart for thousands of cycles, with a control-skip pair in every sixteen-symbol block. It then repeats the run without any pair, so that the occupancy goes on drifting until a sticky flag must set. Every non-pattern symbol is matched in order against a queue, and the number of doubled skip runs is compared with the count of insert strobes.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;

    localparam int SYM_W = 10;
    localparam int PTR_W = 5;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [PTR_W-1:0] ptr_t;

    typedef struct packed {
        logic vld;
        sym_t sym;
    } beat_t;

    typedef enum logic [1:0] {
        RD_FILL   = 2'd0,
        RD_RUN    = 2'd1,
        RD_REPEAT = 2'd2
    } rd_phase_e;

    function automatic ptr_t bin2gray(ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray2bin(ptr_t g);
        ptr_t b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ebuf_ptr_sync.sv
module ebuf_ptr_sync
    import ebuf_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  ptr_t gray_in,
    output ptr_t bin_out
);

    ptr_t stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= gray_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign bin_out = gray2bin(stage_q[STAGES-1]);

endmodule

// File: rtl/ebuf_store.sv
module ebuf_store
    import ebuf_pkg::*;
#(
    parameter int DEPTH = 20,
    parameter int AW    = 5
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  sym_t          wdata,
    input  logic [AW-1:0] raddr,
    output sym_t          rdata
);

    sym_t mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/ebuf_wr_ctl.sv
module ebuf_wr_ctl
    import ebuf_pkg::*;
#(
    parameter int DEPTH   = 20,
    parameter int AW      = 5,
    parameter int DEL_LVL = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  sym_t          in_sym,
    input  sym_t          ctrl_sym,
    input  sym_t          skip_sym,
    input  ptr_t          rptr_seen,
    output logic          we,
    output logic [AW-1:0] waddr,
    output ptr_t          wgray,
    output logic          del_stb,
    output logic          ovf_flag
);

    localparam ptr_t DEL_P  = ptr_t'(DEL_LVL);
    localparam ptr_t FULL_P = ptr_t'(DEPTH);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    ptr_t          wptr_q, wgray_q;
    logic [AW-1:0] waddr_q;
    logic          prev_ctrl_q, del_q, ovf_q;
    ptr_t          fill;
    logic          drop, full;

    always_comb begin
        fill = wptr_q - rptr_seen;
        drop = prev_ctrl_q && (in_sym == skip_sym) && (fill >= DEL_P);
        full = (fill >= FULL_P);
        we   = !drop && !full;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q      <= '0;
            wgray_q     <= '0;
            waddr_q     <= '0;
            prev_ctrl_q <= 1'b0;
            del_q       <= 1'b0;
            ovf_q       <= 1'b0;
        end else begin
            prev_ctrl_q <= (in_sym == ctrl_sym);
            del_q       <= drop;
            wgray_q     <= bin2gray(wptr_q);
            if (full && !drop) ovf_q <= 1'b1;
            if (we) begin
                wptr_q  <= wptr_q + 1'b1;
                waddr_q <= (waddr_q == LAST_A) ? '0 : waddr_q + 1'b1;
            end
        end
    end

    assign waddr    = waddr_q;
    assign wgray    = wgray_q;
    assign del_stb  = del_q;
    assign ovf_flag = ovf_q;

endmodule

// File: rtl/ebuf_rd_ctl.sv
module ebuf_rd_ctl
    import ebuf_pkg::*;
#(
    parameter int DEPTH     = 20,
    parameter int AW        = 5,
    parameter int START_LVL = 7,
    parameter int INS_LVL   = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  sym_t          ctrl_sym,
    input  sym_t          skip_sym,
    input  ptr_t          wptr_seen,
    input  sym_t          rdata,
    output logic [AW-1:0] raddr,
    output ptr_t          rgray,
    output beat_t         beat,
    output logic          ins_stb,
    output logic          udf_flag
);

    localparam ptr_t START_P = ptr_t'(START_LVL);
    localparam ptr_t INS_P   = ptr_t'(INS_LVL);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH - 1);

    rd_phase_e     phase_q;
    ptr_t          rptr_q, rgray_q;
    logic [AW-1:0] raddr_q;
    logic          last_ctrl_q, ins_q, udf_q;
    beat_t         beat_q;
    ptr_t          fill;

    assign fill = wptr_seen - rptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q     <= RD_FILL;
            rptr_q      <= '0;
            rgray_q     <= '0;
            raddr_q     <= '0;
            last_ctrl_q <= 1'b0;
            ins_q       <= 1'b0;
            udf_q       <= 1'b0;
            beat_q      <= '0;
        end else begin
            ins_q   <= 1'b0;
            rgray_q <= bin2gray(rptr_q);
            unique case (phase_q)
                RD_FILL: begin
                    beat_q.vld <= 1'b0;
                    if (fill >= START_P) phase_q <= RD_RUN;
                end
                RD_RUN: begin
                    if (fill == '0) begin
                        beat_q.vld <= 1'b0;
                        udf_q      <= 1'b1;
                    end else begin
                        beat_q      <= '{vld: 1'b1, sym: rdata};
                        rptr_q      <= rptr_q + 1'b1;
                        raddr_q     <= (raddr_q == LAST_A) ? '0 : raddr_q + 1'b1;
                        last_ctrl_q <= (rdata == ctrl_sym);
                        if (last_ctrl_q && (rdata == skip_sym) && (fill <= INS_P))
                            phase_q <= RD_REPEAT;
                    end
                end
                RD_REPEAT: begin
                    beat_q      <= '{vld: 1'b1, sym: skip_sym};
                    ins_q       <= 1'b1;
                    last_ctrl_q <= 1'b0;
                    phase_q     <= RD_RUN;
                end
                default: phase_q <= RD_FILL;
            endcase
        end
    end

    assign raddr    = raddr_q;
    assign rgray    = rgray_q;
    assign beat     = beat_q;
    assign ins_stb  = ins_q;
    assign udf_flag = udf_q;

endmodule

// File: rtl/elastic_buf.sv
module elastic_buf
    import ebuf_pkg::*;
#(
    parameter int DEPTH    = 20,
    parameter int MID_LVL  = 10,
    parameter int BAND     = 3,
    parameter int SYNC_LAT = 3
) (
    input  logic             wclk,
    input  logic             wrst,
    input  logic [SYM_W-1:0] in_sym,
    output logic             del_stb,
    output logic             ovf_flag,
    input  logic             rclk,
    input  logic             rrst,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_sym,
    output logic             ins_stb,
    output logic             udf_flag,
    input  logic [SYM_W-1:0] ctrl_sym,
    input  logic [SYM_W-1:0] skip_sym
);

    localparam int AW        = $clog2(DEPTH);
    localparam int START_LVL = MID_LVL - SYNC_LAT;
    localparam int DEL_LVL   = MID_LVL + BAND + SYNC_LAT;
    localparam int INS_LVL   = MID_LVL - BAND - SYNC_LAT;

    logic          we;
    logic [AW-1:0] waddr, raddr;
    ptr_t          wgray, rgray, wptr_rd, rptr_wr;
    sym_t          rdata;
    beat_t         beat;

    ebuf_wr_ctl #(.DEPTH(DEPTH), .AW(AW), .DEL_LVL(DEL_LVL)) i_wr (
        .clk(wclk), .rst(wrst), .in_sym(in_sym), .ctrl_sym(ctrl_sym),
        .skip_sym(skip_sym), .rptr_seen(rptr_wr), .we(we), .waddr(waddr),
        .wgray(wgray), .del_stb(del_stb), .ovf_flag(ovf_flag)
    );

    ebuf_store #(.DEPTH(DEPTH), .AW(AW)) i_store (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(in_sym),
        .raddr(raddr), .rdata(rdata)
    );

    ebuf_ptr_sync #(.STAGES(2)) i_w2r (
        .clk(rclk), .rst(rrst), .gray_in(wgray), .bin_out(wptr_rd)
    );

    ebuf_ptr_sync #(.STAGES(2)) i_r2w (
        .clk(wclk), .rst(wrst), .gray_in(rgray), .bin_out(rptr_wr)
    );

    ebuf_rd_ctl #(.DEPTH(DEPTH), .AW(AW), .START_LVL(START_LVL), .INS_LVL(INS_LVL)) i_rd (
        .clk(rclk), .rst(rrst), .ctrl_sym(ctrl_sym), .skip_sym(skip_sym),
        .wptr_seen(wptr_rd), .rdata(rdata), .raddr(raddr), .rgray(rgray),
        .beat(beat), .ins_stb(ins_stb), .udf_flag(udf_flag)
    );

    assign out_valid = beat.vld;
    assign out_sym   = beat.sym;

endmodule

// File: rtl/elastic_buf_chk.sv
module elastic_buf_chk
    import ebuf_pkg::*;
(
    input logic             wclk,
    input logic             wrst,
    input logic             del_stb,
    input logic             ovf_flag,
    input logic             rclk,
    input logic             rrst,
    input logic             out_valid,
    input logic [SYM_W-1:0] out_sym,
    input logic             ins_stb,
    input logic             udf_flag,
    input logic [SYM_W-1:0] skip_sym
);

    p_wr_quiet_r1: assert property (@(posedge wclk) wrst |=> (!del_stb && !ovf_flag))
        else $error("write side not quiet after reset");

    p_rd_quiet_r1: assert property (@(posedge rclk) rrst |=> (!out_valid && !ins_stb && !udf_flag))
        else $error("read side not quiet after reset");

    p_ovf_sticky_r3: assert property (@(posedge wclk) disable iff (wrst) ovf_flag |=> ovf_flag)
        else $error("overflow flag dropped");

    p_udf_sticky_r4: assert property (@(posedge rclk) disable iff (rrst) udf_flag |=> udf_flag)
        else $error("underflow flag dropped");

    p_del_single_r6: assert property (@(posedge wclk) disable iff (wrst) del_stb |=> !del_stb)
        else $error("delete strobe longer than one cycle");

    p_ins_repeat_r7: assert property (@(posedge rclk) disable iff (rrst)
            ins_stb |-> (out_valid && out_sym == skip_sym && $past(out_sym) == skip_sym))
        else $error("insert strobe without repeated skip");

    p_ins_single_r7: assert property (@(posedge rclk) disable iff (rrst) ins_stb |=> !ins_stb)
        else $error("insert strobe longer than one cycle");

endmodule

bind elastic_buf elastic_buf_chk i_chk (
    .wclk(wclk), .wrst(wrst), .del_stb(del_stb), .ovf_flag(ovf_flag),
    .rclk(rclk), .rrst(rrst), .out_valid(out_valid), .out_sym(out_sym),
    .ins_stb(ins_stb), .udf_flag(udf_flag), .skip_sym(skip_sym)
);

// File: tb/test_elastic_buf.sv
module test_elastic_buf;
    import ebuf_pkg::*;

    localparam sym_t CTRL = 10'h283;
    localparam sym_t SKIP = 10'h2A5;

    logic wclk = 1'b0, rclk = 1'b0, wrst = 1'b1, rrst = 1'b1;
    sym_t in_sym = '0;
    logic del_stb, ovf_flag, out_valid, ins_stb, udf_flag;
    sym_t out_sym;

    int whalf = 10000, rhalf = 10000;
    int checks = 0, errors = 0;
    bit done = 0;

    bit   mon_en = 0, cmp_en = 0, after_ctrl = 0, seen_valid = 0;
    sym_t exp_q[$];
    sym_t first_out, first_in, data_ctr = '0;
    int   mism, ins_cnt, del_cnt, runs2, runs_bad, run_len, wr_cnt, first_valid_wr;

    elastic_buf i_elastic_buf (
        .wclk(wclk), .wrst(wrst), .in_sym(in_sym), .del_stb(del_stb), .ovf_flag(ovf_flag),
        .rclk(rclk), .rrst(rrst), .out_valid(out_valid), .out_sym(out_sym),
        .ins_stb(ins_stb), .udf_flag(udf_flag), .ctrl_sym(CTRL), .skip_sym(SKIP)
    );

    initial forever #(whalf) wclk = ~wclk;
    initial begin
        #3000;
        forever #(rhalf) rclk = ~rclk;
    end

    always @(negedge wclk) if (mon_en && del_stb) del_cnt++;

    always @(negedge rclk) begin
        if (mon_en) begin
            if (ins_stb) ins_cnt++;
            if (out_valid) begin
                if (!seen_valid) begin
                    seen_valid     = 1;
                    first_valid_wr = wr_cnt;
                    first_out      = out_sym;
                end
                if (out_sym == SKIP && after_ctrl) begin
                    run_len++;
                    if (run_len == 2) runs2++;
                    if (run_len > 2) runs_bad++;
                end else begin
                    run_len    = 0;
                    after_ctrl = (out_sym == CTRL);
                    if (cmp_en) begin
                        if (exp_q.size() == 0) mism++;
                        else if (exp_q.pop_front() != out_sym) mism++;
                    end
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge wclk);
        check(0, "watchdog", "run did not end", 0, 1);
        finish_run();
    end

    function automatic sym_t next_data();
        data_ctr = data_ctr + 1'b1;
        while (data_ctr == CTRL || data_ctr == SKIP) data_ctr = data_ctr + 1'b1;
        return data_ctr;
    endfunction

    task automatic start_scn(input int wh, input int rh, input bit cmp);
        mon_en = 0;
        wrst = 1; rrst = 1;
        whalf = wh; rhalf = rh;
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
        exp_q.delete();
        mism = 0; ins_cnt = 0; del_cnt = 0; runs2 = 0; runs_bad = 0; run_len = 0;
        wr_cnt = 0; after_ctrl = 0; seen_valid = 0; cmp_en = cmp;
        @(negedge rclk);
        rrst = 0;
        mon_en = 1;
    endtask

    // pat: control-skip pair per 16-symbol block; ctrl_only: control without skip; lone: unpaired skip
    task automatic drive(input int n, input bit pat, input bit ctrl_only, input bit lone);
        for (int i = 0; i < n; i++) begin
            sym_t s;
            bit   pat_skip;
            int   slot;
            slot = i % 16;
            pat_skip = 0;
            if ((pat || ctrl_only) && slot == 0) s = CTRL;
            else if (pat && slot == 1) begin s = SKIP; pat_skip = 1; end
            else if (lone && slot == 6) s = SKIP;
            else s = next_data();
            @(negedge wclk);
            in_sym = s;
            wrst = 0;
            if (i == 0) first_in = s;
            if (!pat_skip) exp_q.push_back(s);
            wr_cnt++;
        end
        mon_en = 0;
    endtask

    task automatic t_reset();
        wrst = 1; rrst = 1;
        repeat (3) @(negedge rclk);
        repeat (3) @(negedge wclk);
        check(out_valid == 0, "R1", "out_valid in reset", out_valid, 0);
        check(udf_flag == 0 && ins_stb == 0, "R1", "read flags in reset", udf_flag + ins_stb, 0);
        check(ovf_flag == 0 && del_stb == 0, "R1", "write flags in reset", ovf_flag + del_stb, 0);
    endtask

    task automatic t_start();
        start_scn(10000, 10000, 1);
        drive(300, 1, 0, 0);
        check(seen_valid, "R2", "output started", seen_valid, 1);
        check(first_valid_wr >= 10, "R2", "writes before first output", first_valid_wr, 10);
        check(first_out == first_in, "R2", "first output symbol", first_out, first_in);
        check(mism == 0, "R5", "order mismatches", mism, 0);
    endtask

    task automatic t_equal();
        start_scn(10000, 10000, 1);
        drive(3000, 1, 0, 1);
        check(del_cnt == 0 && ins_cnt == 0, "R9", "compensations at equal rate", del_cnt + ins_cnt, 0);
        check(mism == 0, "R5", "order with lone skips", mism, 0);
        check(ovf_flag == 0 && udf_flag == 0, "R9", "flags at equal rate", ovf_flag + udf_flag, 0);
    endtask

    task automatic t_fast_write();
        start_scn(9800, 10000, 1);
        drive(4000, 1, 0, 1);
        check(del_cnt > 0, "R6", "deletions seen", del_cnt, 1);
        check(ovf_flag == 0, "R6", "overflow with deletion", ovf_flag, 0);
        check(mism == 0, "R5", "order with deletion", mism, 0);
    endtask

    task automatic t_slow_write();
        start_scn(10200, 10000, 1);
        drive(4000, 1, 0, 1);
        check(ins_cnt > 0, "R7", "insertions seen", ins_cnt, 1);
        check(udf_flag == 0, "R7", "underflow with insertion", udf_flag, 0);
        check(runs2 == ins_cnt, "R7", "doubled skips vs strobes", runs2, ins_cnt);
        check(runs_bad == 0, "R7", "skip runs longer than two", runs_bad, 0);
        check(mism == 0, "R5", "order with insertion", mism, 0);
    endtask

    task automatic t_lone_overflow();
        start_scn(9800, 10000, 0);
        drive(4000, 0, 0, 1);
        check(del_cnt == 0, "R8", "lone skips dropped", del_cnt, 0);
        check(ovf_flag == 1, "R3", "overflow without pairs", ovf_flag, 1);
        repeat (50) @(negedge wclk);
        check(ovf_flag == 1, "R3", "overflow sticky", ovf_flag, 1);
    endtask

    task automatic t_underflow();
        start_scn(10200, 10000, 0);
        drive(4000, 0, 1, 1);
        check(ins_cnt == 0, "R8", "insertions without skip pair", ins_cnt, 0);
        check(udf_flag == 1, "R4", "underflow without pairs", udf_flag, 1);
        repeat (50) @(negedge rclk);
        check(udf_flag == 1, "R4", "underflow sticky", udf_flag, 1);
    endtask

    initial begin
        t_reset();
        t_start();
        t_equal();
        t_fast_write();
        t_slow_write();
        t_lone_overflow();
        t_underflow();
        t_reset();
        finish_run();
    end

endmodule